// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches one gated logic domain off and on under software control. Software writes a request bit in a control register. The sequencer then drives two outputs in a fixed order. For a power-down it asserts the isolation enable first and opens the power switch last. For a power-up it closes the power switch first and releases isolation last. The wait between the two actions is the sum of two 6-bit fields in a delay register, counted in bus-clock cycles. Each direction has its own delay register. A gating-enable bit decides whether a power-down request may remove power at all.

A flat register port gives access to four registers: the control register with its pending request bits, the gating-enable register, and the two delay registers. Requests wait their turn. A request that arrives during a sequence stays pending until that sequence ends. When both requests are pending, power-down runs first.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, sw_en = 1, iso_en = 0 and busy = 0. The control and gating-enable registers read 0. Both delay registers read 0x0000_0101.
- R2: The registers sit at these byte offsets: control 0x000, gating enable 0x260, power-up delay 0x264, power-down delay 0x268. A delay register holds its first-phase field in bits [5:0] and its second-phase field in bits [13:8]. Bits outside the defined fields read as 0 and ignore writes. An unmapped address reads 0.
- R3: Writing 1 to control bit 0 (power-down) or control bit 1 (power-up) sets that request. Writing 0 has no effect. A set request reads back as 1 until its sequence completes, and then reads 0.
- R4: A power-down request with gating enabled sets iso_en on the clock edge after the request is stored. It clears sw_en N clock edges later, where N is the sum of the two power-down delay fields. busy is 1 during the wait.
- R5: A power-up request sets sw_en on the clock edge after the request is stored. It clears iso_en N edges later, where N is the sum of the two power-up delay fields. busy is 1 during the wait.
- R6: When the selected delay sum is 0, both outputs change on the same edge and busy stays 0.
- R7: A power-down request while gating enable bit 0 is 0 completes on the next edge. iso_en and sw_en do not change.
- R8: When both request bits are pending in an idle cycle, the power-down sequence runs before the power-up sequence.
- R9: A request written during a running sequence stays pending. It starts only after that sequence ends.
- R10: While sw_en is 0, iso_en is 1.
- R11: iso_en and sw_en change only on an edge where a request was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also counts the delays |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| iso_en | output | 1 | Isolation enable for the domain's outputs |
| sw_en | output | 1 | Power switch closed (domain powered) |
| busy | output | 1 | A sequence is waiting out its delay |

## Verification
The bench uses the default parameters: 6-bit delay fields, a 12-bit address and a 32-bit data path. With these values, sequences from 0 to 126 cycles are reachable, including the largest field values (63 + 63). The vector walk alternates between the two directions over zero, one-sided, small and maximum delay sums. It measures the number of edges between the first and second output actions. Directed tests cover requests that are blocked by the gating enable, requests queued behind a running sequence, and both requests pending together.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DOWN = 2'd1,
        SEQ_UP   = 2'd2
    } seq_state_e;

    // request bit positions in the control register
    localparam int REQ_DN = 0;
    localparam int REQ_UP = 1;

    // delay register index and field index
    localparam int DLY_UP = 0;
    localparam int DLY_DN = 1;
    localparam int FLD_LO = 0;
    localparam int FLD_HI = 1;

endpackage

// File: rtl/pwr_gate_regs.sv
module pwr_gate_regs
    import pwr_gate_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DLY_W  = 6,
    parameter int HI_LSB = 8,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h000,
    parameter logic [ADDR_W-1:0] OFS_GATE = 12'h260,
    parameter logic [ADDR_W-1:0] OFS_UP   = 12'h264,
    parameter logic [ADDR_W-1:0] OFS_DN   = 12'h268
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        req_clr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [1:0]        req_pend,
    output logic              gate_en,
    output logic [DLY_W:0]    up_total,
    output logic [DLY_W:0]    dn_total
);
    localparam int NDLY  = 2;
    localparam int SUM_W = DLY_W + 1;
    localparam logic [ADDR_W-1:0] DLY_OFS [NDLY] = '{OFS_UP, OFS_DN};

    typedef struct packed {
        logic [1:0]                      pend;
        logic                            gate;
        logic [NDLY-1:0][1:0][DLY_W-1:0] dly;
    } regs_t;

    regs_t r_d, r_q;

    logic              dly_hit [NDLY];
    logic [DATA_W-1:0] dly_rd  [NDLY];

    // one read image per delay register
    for (genvar g = 0; g < NDLY; g++) begin : g_dly
        assign dly_hit[g] = (bus_addr == DLY_OFS[g]);
        always_comb begin
            dly_rd[g] = '0;
            dly_rd[g][DLY_W-1:0]         = r_q.dly[g][FLD_LO];
            dly_rd[g][HI_LSB +: DLY_W]   = r_q.dly[g][FLD_HI];
        end
    end

    always_comb begin
        r_d      = r_q;
        // a write that sets a bit wins over a completion that clears it
        r_d.pend = r_q.pend & ~req_clr;
        if (bus_we) begin
            if (bus_addr == OFS_CTRL) begin
                r_d.pend = r_d.pend | bus_wdata[1:0];
            end
            if (bus_addr == OFS_GATE) begin
                r_d.gate = bus_wdata[0];
            end
            for (int i = 0; i < NDLY; i++) begin
                if (bus_addr == DLY_OFS[i]) begin
                    r_d.dly[i][FLD_LO] = bus_wdata[DLY_W-1:0];
                    r_d.dly[i][FLD_HI] = bus_wdata[HI_LSB +: DLY_W];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CTRL) begin
            bus_rdata[1:0] = r_q.pend;
        end
        if (bus_addr == OFS_GATE) begin
            bus_rdata[0] = r_q.gate;
        end
        for (int i = 0; i < NDLY; i++) begin
            if (dly_hit[i]) begin
                bus_rdata = dly_rd[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.pend <= '0;
            r_q.gate <= 1'b0;
            for (int i = 0; i < NDLY; i++) begin
                for (int f = 0; f < 2; f++) begin
                    r_q.dly[i][f] <= DLY_W'(1);
                end
            end
        end else begin
            r_q <= r_d;
        end
    end

    assign req_pend = r_q.pend;
    assign gate_en  = r_q.gate;
    assign up_total = SUM_W'(r_q.dly[DLY_UP][FLD_LO]) + SUM_W'(r_q.dly[DLY_UP][FLD_HI]);
    assign dn_total = SUM_W'(r_q.dly[DLY_DN][FLD_LO]) + SUM_W'(r_q.dly[DLY_DN][FLD_HI]);

endmodule

// File: rtl/pwr_gate_fsm.sv
module pwr_gate_fsm
    import pwr_gate_pkg::*;
#(
    parameter int DLY_W = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     req_pend,
    input  logic           gate_en,
    input  logic [DLY_W:0] up_total,
    input  logic [DLY_W:0] dn_total,
    output logic [1:0]     req_clr,
    output logic           iso_en,
    output logic           sw_en,
    output logic           busy
);
    localparam int CNT_W = DLY_W + 1;

    typedef struct packed {
        seq_state_e       st;
        logic             iso;
        logic             sw;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        req_clr = '0;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (req_pend[REQ_DN]) begin
                    if (!gate_en) begin
                        req_clr[REQ_DN] = 1'b1;
                    end else begin
                        s_d.iso = 1'b1;
                        if (dn_total == '0) begin
                            s_d.sw          = 1'b0;
                            req_clr[REQ_DN] = 1'b1;
                        end else begin
                            s_d.st  = SEQ_DOWN;
                            s_d.cnt = dn_total;
                        end
                    end
                end else if (req_pend[REQ_UP]) begin
                    s_d.sw = 1'b1;
                    if (up_total == '0) begin
                        s_d.iso         = 1'b0;
                        req_clr[REQ_UP] = 1'b1;
                    end else begin
                        s_d.st  = SEQ_UP;
                        s_d.cnt = up_total;
                    end
                end
            end
            SEQ_DOWN: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.sw          = 1'b0;
                    s_d.st          = SEQ_IDLE;
                    req_clr[REQ_DN] = 1'b1;
                end
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            SEQ_UP: begin
                if (s_q.cnt == CNT_W'(1)) begin
                    s_d.iso         = 1'b0;
                    s_d.st          = SEQ_IDLE;
                    req_clr[REQ_UP] = 1'b1;
                end
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= SEQ_IDLE;
            s_q.iso <= 1'b0;
            s_q.sw  <= 1'b1;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign iso_en = s_q.iso;
    assign sw_en  = s_q.sw;
    assign busy   = (s_q.st != SEQ_IDLE);

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int DLY_W  = 6,
    parameter int HI_LSB = 8,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h000,
    parameter logic [ADDR_W-1:0] OFS_GATE = 12'h260,
    parameter logic [ADDR_W-1:0] OFS_UP   = 12'h264,
    parameter logic [ADDR_W-1:0] OFS_DN   = 12'h268
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              iso_en,
    output logic              sw_en,
    output logic              busy
);
    logic [1:0]     req_pend;
    logic [1:0]     req_clr;
    logic           gate_en;
    logic [DLY_W:0] up_total;
    logic [DLY_W:0] dn_total;

    pwr_gate_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W), .HI_LSB(HI_LSB),
        .OFS_CTRL(OFS_CTRL), .OFS_GATE(OFS_GATE), .OFS_UP(OFS_UP), .OFS_DN(OFS_DN)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .req_clr  (req_clr),
        .bus_rdata(bus_rdata),
        .req_pend (req_pend),
        .gate_en  (gate_en),
        .up_total (up_total),
        .dn_total (dn_total)
    );

    pwr_gate_fsm #(
        .DLY_W(DLY_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_pend(req_pend),
        .gate_en (gate_en),
        .up_total(up_total),
        .dn_total(dn_total),
        .req_clr (req_clr),
        .iso_en  (iso_en),
        .sw_en   (sw_en),
        .busy    (busy)
    );

endmodule

// File: rtl/pwr_gate_seq_chk.sv
module pwr_gate_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] OFS_CTRL = 12'h000,
    parameter logic [ADDR_W-1:0] OFS_GATE = 12'h260,
    parameter logic [ADDR_W-1:0] OFS_UP   = 12'h264,
    parameter logic [ADDR_W-1:0] OFS_DN   = 12'h268
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              iso_en,
    input logic              sw_en,
    input logic              busy,
    input logic [1:0]        req_pend,
    input logic              gate_en
);
    logic unmapped;
    assign unmapped = (bus_addr != OFS_CTRL) && (bus_addr != OFS_GATE) &&
                      (bus_addr != OFS_UP) && (bus_addr != OFS_DN);

    AST_OPEN_NEEDS_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> iso_en); // R10

    AST_OUT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sw_en) || !$stable(iso_en)) |-> ($past(req_pend) != 2'b00)); // R11

    AST_OFF_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_en) |-> $past(gate_en)); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (bus_rdata == '0)); // R2

    AST_CTRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CTRL) |-> (bus_rdata[DATA_W-1:2] == '0)); // R3

    AST_BUSY_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (req_pend != 2'b00)); // R9

endmodule

bind pwr_gate_seq pwr_gate_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .OFS_CTRL(OFS_CTRL), .OFS_GATE(OFS_GATE), .OFS_UP(OFS_UP), .OFS_DN(OFS_DN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .iso_en   (iso_en),
    .sw_en    (sw_en),
    .busy     (busy),
    .req_pend (req_pend),
    .gate_en  (gate_en)
);

// File: tb/pwr_gate_seq_tb.sv
module pwr_gate_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_GATE = 12'h260;
    localparam logic [11:0] A_UP   = 12'h264;
    localparam logic [11:0] A_DN   = 12'h268;

    typedef struct packed {
        logic       down;
        logic [5:0] lo;
        logic [5:0] hi;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 6'd1,  6'd1},  '{1'b0, 6'd1,  6'd1},
        '{1'b1, 6'd3,  6'd5},  '{1'b0, 6'd0,  6'd7},
        '{1'b1, 6'd63, 6'd63}, '{1'b0, 6'd63, 6'd0},
        '{1'b1, 6'd0,  6'd0},  '{1'b0, 6'd0,  6'd0},
        '{1'b1, 6'd0,  6'd9},  '{1'b0, 6'd5,  6'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        iso_en, sw_en, busy;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_gate_seq u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .iso_en(iso_en), .sw_en(sw_en), .busy(busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // counts falling edges until the chosen output (0 = iso_en, 1 = sw_en) equals val
    task automatic wait_for(input int which, input logic val, output int cnt);
        cnt = 0;
        for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            if (((which == 0) ? iso_en : sw_en) === val) begin
                cnt = k;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, no requirement reached completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        int cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 sw_en", {31'd0, sw_en}, 32'd1);
        check("R1 iso_en", {31'd0, iso_en}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
        rd(A_GATE, d); check("R1 gate", d, 32'h0);
        rd(A_UP, d);   check("R1 up delay", d, 32'h0000_0101);
        rd(A_DN, d);   check("R1 down delay", d, 32'h0000_0101);

        // R2 field placement, unused bits, unmapped address
        wr(A_UP, 32'hFFFF_FFFF);
        rd(A_UP, d); check("R2 up fields only", d, 32'h0000_3F3F);
        wr(A_GATE, 32'hFFFF_FFFE);
        rd(A_GATE, d); check("R2 gate bit0 only", d, 32'h0);
        wr(12'h104, 32'hFFFF_FFFF);
        rd(12'h104, d); check("R2 unmapped read", d, 32'h0);
        rd(A_DN, d); check("R2 unmapped write ignored", d, 32'h0000_0101);

        // R3 writing zero to control does nothing
        wr(A_CTRL, 32'h0);
        @(negedge clk);
        check("R3 zero write busy", {31'd0, busy}, 32'd0);
        check("R3 zero write sw_en", {31'd0, sw_en}, 32'd1);
        rd(A_CTRL, d); check("R3 zero write ctrl", d, 32'h0);

        // R7 power-down blocked by gating enable = 0
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, d); check("R3 pending visible", d, 32'h1);
        @(negedge clk);
        rd(A_CTRL, d); check("R7 blocked request cleared", d, 32'h0);
        check("R7 sw_en unchanged", {31'd0, sw_en}, 32'd1);
        check("R7 iso_en unchanged", {31'd0, iso_en}, 32'd0);
        check("R7 busy", {31'd0, busy}, 32'd0);

        wr(A_GATE, 32'h1);

        // vector walk: R4, R5, R6
        for (int v = 0; v < NVEC; v++) begin
            n = int'(VECS[v].lo) + int'(VECS[v].hi);
            wr(VECS[v].down ? A_DN : A_UP, {18'd0, VECS[v].hi, 2'b00, VECS[v].lo});
            wr(A_CTRL, VECS[v].down ? 32'h1 : 32'h2);
            @(negedge clk);
            if (VECS[v].down) begin
                check($sformatf("R4 v%0d iso first", v), {31'd0, iso_en}, 32'd1);
            end else begin
                check($sformatf("R5 v%0d sw first", v), {31'd0, sw_en}, 32'd1);
            end
            if (n == 0) begin
                check($sformatf("R6 v%0d busy stays low", v), {31'd0, busy}, 32'd0);
                check($sformatf("R6 v%0d second action same edge", v),
                      {31'd0, VECS[v].down ? sw_en : iso_en}, 32'd0);
            end else begin
                check($sformatf("R4/R5 v%0d busy", v), {31'd0, busy}, 32'd1);
                wait_for(VECS[v].down ? 1 : 0, 1'b0, cnt);
                check($sformatf("R4/R5 v%0d delay edges", v), cnt, n);
                check($sformatf("R4/R5 v%0d busy done", v), {31'd0, busy}, 32'd0);
            end
            rd(A_CTRL, d); check($sformatf("R3 v%0d request cleared", v), d, 32'h0);
        end

        // R8 both requests at once: power-down first
        wr(A_DN, 32'h0000_0101);
        wr(A_UP, 32'h0000_0101);
        wr(A_CTRL, 32'h3);
        @(negedge clk);
        check("R8 iso first", {31'd0, iso_en}, 32'd1);
        check("R8 switch still closed", {31'd0, sw_en}, 32'd1);
        wait_for(1, 1'b0, cnt);
        check("R8 down completes", cnt, 2);
        rd(A_CTRL, d); check("R8 up still pending", d, 32'h2);
        wait_for(1, 1'b1, cnt);
        check("R8 up starts next edge", cnt, 1);
        wait_for(0, 1'b0, cnt);
        check("R8 up completes", cnt, 2);
        rd(A_CTRL, d); check("R8 all cleared", d, 32'h0);

        // R9 request held behind a running sequence
        wr(A_DN, 32'h0000_0604);
        wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, d); check("R9 both pending", d, 32'h3);
        check("R9 switch not yet open", {31'd0, sw_en}, 32'd1);
        wait_for(1, 1'b0, cnt);
        check("R9 down not disturbed", cnt, 6);
        wait_for(1, 1'b1, cnt);
        check("R9 held up runs after", cnt, 1);
        wait_for(0, 1'b0, cnt);
        check("R9 up completes", cnt, 2);
        check("R10 powered and released", {30'd0, sw_en, iso_en}, 32'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule